// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block is the per-processor front end of an interrupt controller. It receives the ID of the best pending interrupt from separate selection logic. Through a small register window the processor can enable the interface, set a priority mask, acknowledge the interrupt it is being offered, signal end-of-interrupt (EOI), and read the running priority and the highest pending ID. The block tracks the running interrupt and its priority. When a higher-priority interrupt is acknowledged, the interrupt it preempts is stored as a per-interrupt back link. This forms a chain, so nested handlers unwind in order.

An acknowledge clears the taken interrupt's pending state, using a one-cycle pulse to the pending logic. An EOI pops the chain when it names the running interrupt. When it names an interrupt deeper in the chain, the block walks the links and splices that entry out. During the walk the bus is held off. A level-sensitive source that is still asserted, enabled and aimed at this processor is sent back to pending on EOI, again through a one-cycle pulse.

The controller has two states. `ST_IDLE` accepts bus accesses. `ST_WALK` follows the chain one link per cycle. The transition *start_walk* (`ST_IDLE` to `ST_WALK`) fires on an EOI for a valid, non-running ID while something is running. The transition *walk_end* (`ST_WALK` to `ST_IDLE`) fires when one of three things happens: the matching link is found and replaced, the end of the chain (1023) is reached, or `NUM_IRQ` steps have been taken.

Top module: `ackeoi_tracker`

## Requirements
- R1: After reset the running ID is 1023 and the running priority reads 0x100. Control and mask are 0, `bus_ready` is 1, `cpu_irq` is 0 and no pulse is active.
- R2: Offset 0x18 reads the highest pending ID. This equals `hp_id` when three conditions hold: control bit 0 is set, `hp_id` < `NUM_IRQ`, and that ID's priority is strictly below the 8-bit mask at offset 0x04. Otherwise it reads 1023. `cpu_irq` is high exactly when this value is not 1023 and its priority is strictly below the running priority.
- R3: A read of offset 0x0C returns 1023 and changes nothing if the highest pending ID is 1023 or its priority is not strictly below the running priority.
- R4: A successful acknowledge read returns the ID. It stores the prior running ID as that ID's link, makes the ID running at its own priority, and pulses `pend_clr_vld` for one cycle with `pend_clr_id` equal to the ID.
- R5: Whenever the running ID is 1023, the running priority (offset 0x14) reads 0x100.
- R6: A write to offset 0x10 (EOI, ID in bits 9:0) with an ID at or above `NUM_IRQ`, including 1023, is ignored.
- R7: An EOI while the running ID is 1023 is ignored, including the re-pend of R10.
- R8: An EOI for the running interrupt makes its stored link the running ID, with that link's priority.
- R9: An EOI for a valid non-running ID walks the chain from the running ID. The first entry whose link equals the ID takes the completed ID's link. The running ID is unchanged. `bus_ready` is low while the walk runs, and the walk lasts at most `NUM_IRQ` cycles.
- R10: On an EOI accepted under R6/R7, a re-pend happens when the ID is level-triggered (`irq_edge` 0), enabled, has `irq_level` high and `irq_to_cpu` set. The block then pulses `pend_set_vld` for one cycle with that ID, in the same cycle as any chain pop.
- R11: Offset 0x00 holds control (bit 0 enable) and 0x04 the priority mask (bits 7:0). Reads from any undefined offset return 0, and writes to it change no register.
- R12: A read is accepted when `bus_req` and `bus_ready` are high at a clock edge. `bus_rvalid` and `bus_rdata` are valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted this cycle when high with request |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| hp_id | input | 10 | Best pending ID from the selector, 1023 for none |
| prio_tbl | input | NUM_IRQ*PRIO_W | Priority of interrupt i in bits i*PRIO_W upward |
| irq_enable | input | NUM_IRQ | Per-interrupt enable |
| irq_edge | input | NUM_IRQ | 1 = edge-triggered, 0 = level |
| irq_level | input | NUM_IRQ | Current input level |
| irq_to_cpu | input | NUM_IRQ | Interrupt targets this processor |
| cpu_irq | output | 1 | Interrupt request to the processor |
| pend_clr_vld | output | 1 | Clear-pending pulse |
| pend_clr_id | output | 10 | ID to clear |
| pend_set_vld | output | 1 | Set-pending pulse |
| pend_set_id | output | 10 | ID to set pending |

## Verification
Two functions can land on the same edge: the chain pop of an EOI and the re-pend of that same level-sensitive interrupt. The bench drives a level-triggered, enabled, targeted source high and acknowledges it, then sends its EOI. It then requires both the set-pending pulse with the right ID and the idle running priority to be observed after that single access. A second overlap, an access arriving while a chain walk is in progress, is provoked by splicing out the deepest entry of a four-deep chain. It is judged by `bus_ready` dropping, and by the later pops restoring the expected priorities in order.

// File: rtl/ackeoi_pkg.sv
package ackeoi_pkg;
    localparam int          ID_W       = 10;
    localparam logic [9:0]  ID_NONE    = 10'd1023;
    localparam logic [8:0]  PRIO_IDLE  = 9'h100;

    localparam logic [7:0]  OFS_CTRL   = 8'h00;
    localparam logic [7:0]  OFS_PMASK  = 8'h04;
    localparam logic [7:0]  OFS_ACK    = 8'h0C;
    localparam logic [7:0]  OFS_EOI    = 8'h10;
    localparam logic [7:0]  OFS_RPRIO  = 8'h14;
    localparam logic [7:0]  OFS_HPEND  = 8'h18;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } trk_state_t;
endpackage

// File: rtl/ackeoi_prio_lut.sv
module ackeoi_prio_lut #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [9:0]                irq_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] tbl,
    output logic [PRIO_W:0]           prio
);
    // IDs outside the implemented range (including 1023) map to idle.
    always_comb begin
        prio = {1'b1, {PRIO_W{1'b0}}};
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (irq_id == 10'(i)) prio = {1'b0, tbl[i*PRIO_W +: PRIO_W]};
        end
    end
endmodule

// File: rtl/ackeoi_link_store.sv
module ackeoi_link_store #(
    parameter int NUM_IRQ = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [9:0] waddr,
    input  logic [9:0] wdata,
    input  logic [9:0] raddr_a,
    output logic [9:0] rdata_a,
    input  logic [9:0] raddr_b,
    output logic [9:0] rdata_b
);
    logic [9:0] links [NUM_IRQ];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) links[i] <= ackeoi_pkg::ID_NONE;
        end else if (we) begin
            for (int i = 0; i < NUM_IRQ; i++)
                if (waddr == 10'(i)) links[i] <= wdata;
        end
    end

    always_comb begin
        rdata_a = ackeoi_pkg::ID_NONE;
        rdata_b = ackeoi_pkg::ID_NONE;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (raddr_a == 10'(i)) rdata_a = links[i];
            if (raddr_b == 10'(i)) rdata_b = links[i];
        end
    end
endmodule

// File: rtl/ackeoi_tracker.sv
module ackeoi_tracker #(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic                      bus_ready,
    output logic                      bus_rvalid,
    output logic [31:0]               bus_rdata,
    input  logic [9:0]                hp_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_tbl,
    input  logic [NUM_IRQ-1:0]        irq_enable,
    input  logic [NUM_IRQ-1:0]        irq_edge,
    input  logic [NUM_IRQ-1:0]        irq_level,
    input  logic [NUM_IRQ-1:0]        irq_to_cpu,
    output logic                      cpu_irq,
    output logic                      pend_clr_vld,
    output logic [9:0]                pend_clr_id,
    output logic                      pend_set_vld,
    output logic [9:0]                pend_set_id
);
    import ackeoi_pkg::*;

    localparam int CNT_W = $clog2(NUM_IRQ + 1);

    trk_state_t        state, state_nx;
    logic              ctrl_en;
    logic [PRIO_W-1:0] pmask;
    logic [9:0]        run_id;
    logic [PRIO_W:0]   run_prio;
    logic [9:0]        walk_cur, walk_eoi;
    logic [CNT_W-1:0]  walk_cnt;

    logic [PRIO_W:0]   hp_prio, pop_prio;
    logic [9:0]        cur_pend, link_a, link_b, eoi_id, lnk_waddr, lnk_wdata;
    logic              acc, rd_ack, ack_ok, eoi_wr, eoi_live, eoi_pop, eoi_walk;
    logic              repend, walk_hit, walk_end, lnk_we;

    ackeoi_prio_lut #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_lut_hp (
        .irq_id(hp_id), .tbl(prio_tbl), .prio(hp_prio));

    ackeoi_prio_lut #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_lut_pop (
        .irq_id(link_a), .tbl(prio_tbl), .prio(pop_prio));

    ackeoi_link_store #(.NUM_IRQ(NUM_IRQ)) u_links (
        .clk(clk), .rst_n(rst_n), .we(lnk_we), .waddr(lnk_waddr), .wdata(lnk_wdata),
        .raddr_a((state == ST_WALK) ? walk_cur : run_id), .rdata_a(link_a),
        .raddr_b(walk_eoi), .rdata_b(link_b));

    // Offer and acknowledge qualification
    assign cur_pend  = (ctrl_en && hp_prio < {1'b0, pmask}) ? hp_id : ID_NONE;
    assign ack_ok    = (cur_pend != ID_NONE) && (hp_prio < run_prio);
    assign cpu_irq   = ack_ok;

    assign bus_ready = (state == ST_IDLE);
    assign acc       = bus_req && bus_ready;
    assign rd_ack    = acc && !bus_we && bus_addr == OFS_ACK;
    assign eoi_wr    = acc && bus_we && bus_addr == OFS_EOI;
    assign eoi_id    = bus_wdata[9:0];
    assign eoi_live  = eoi_wr && (32'(eoi_id) < NUM_IRQ) && (run_id != ID_NONE);
    assign eoi_pop   = eoi_live && (eoi_id == run_id);
    assign eoi_walk  = eoi_live && (eoi_id != run_id);

    always_comb begin
        repend = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++)
            if (eoi_id == 10'(i))
                repend = !irq_edge[i] && irq_enable[i] && irq_level[i] && irq_to_cpu[i];
        repend = repend && eoi_live;
    end

    // Chain walk step
    assign walk_hit = (state == ST_WALK) && (link_a == walk_eoi);
    assign walk_end = (state == ST_WALK) &&
                      (walk_hit || link_a == ID_NONE || walk_cnt == CNT_W'(NUM_IRQ - 1));

    always_comb begin
        lnk_we    = 1'b0;
        lnk_waddr = cur_pend;
        lnk_wdata = run_id;
        if (rd_ack && ack_ok) begin
            lnk_we = 1'b1;
        end else if (walk_hit) begin
            lnk_we    = 1'b1;
            lnk_waddr = walk_cur;
            lnk_wdata = link_b;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state: start_walk / walk_end
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (eoi_walk) state_nx = ST_WALK;
            ST_WALK: if (walk_end) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en      <= 1'b0;
            pmask        <= '0;
            run_id       <= ID_NONE;
            run_prio     <= {1'b1, {PRIO_W{1'b0}}};
            walk_cur     <= ID_NONE;
            walk_eoi     <= ID_NONE;
            walk_cnt     <= '0;
            bus_rvalid   <= 1'b0;
            bus_rdata    <= '0;
            pend_clr_vld <= 1'b0;
            pend_clr_id  <= ID_NONE;
            pend_set_vld <= 1'b0;
            pend_set_id  <= ID_NONE;
        end else begin
            bus_rvalid   <= acc && !bus_we;
            pend_clr_vld <= rd_ack && ack_ok;
            pend_clr_id  <= cur_pend;
            pend_set_vld <= repend;
            pend_set_id  <= eoi_id;
            if (acc && !bus_we) begin
                unique case (bus_addr)
                    OFS_CTRL:  bus_rdata <= {31'b0, ctrl_en};
                    OFS_PMASK: bus_rdata <= 32'(pmask);
                    OFS_ACK:   bus_rdata <= ack_ok ? 32'(cur_pend) : 32'(ID_NONE);
                    OFS_RPRIO: bus_rdata <= 32'(run_prio);
                    OFS_HPEND: bus_rdata <= 32'(cur_pend);
                    default:   bus_rdata <= '0;
                endcase
            end
            if (acc && bus_we && bus_addr == OFS_CTRL)  ctrl_en <= bus_wdata[0];
            if (acc && bus_we && bus_addr == OFS_PMASK) pmask   <= bus_wdata[PRIO_W-1:0];
            if (rd_ack && ack_ok) begin
                run_id   <= cur_pend;
                run_prio <= hp_prio;
            end else if (eoi_pop) begin
                run_id   <= link_a;
                run_prio <= pop_prio;
            end
            if (eoi_walk) begin
                walk_cur <= run_id;
                walk_eoi <= eoi_id;
                walk_cnt <= '0;
            end else if (state == ST_WALK && !walk_end) begin
                walk_cur <= link_a;
                walk_cnt <= walk_cnt + 1'b1;
            end
        end
    end

    // Assertions
    a_r4_ack_runs: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_vld |-> run_id == pend_clr_id);
    a_r4_prio_drop: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_vld |-> run_prio < $past(run_prio));
    a_r5_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        run_id == ID_NONE |-> run_prio == {1'b1, {PRIO_W{1'b0}}});
    a_r6_bad_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && 32'(eoi_id) >= NUM_IRQ) |=> $stable(run_id) && !pend_set_vld);
    a_r7_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && run_id == ID_NONE) |=> run_id == ID_NONE && !pend_set_vld);
    a_r9_walk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WALK |-> 32'(walk_cnt) < NUM_IRQ);
    a_r9_walk_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WALK |=> $stable(run_id));
    a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));
endmodule

// File: tb/ackeoi_tracker_bench.sv
module ackeoi_tracker_bench;
    localparam int NUM_IRQ = 64;
    localparam int PRIO_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_ready, bus_rvalid, cpu_irq, pend_clr_vld, pend_set_vld;
    logic [31:0] bus_rdata;
    logic [9:0]  hp_id = 10'd1023, pend_clr_id, pend_set_id;
    logic [NUM_IRQ*PRIO_W-1:0] prio_tbl;
    logic [NUM_IRQ-1:0] irq_enable = '0, irq_edge = '0, irq_level = '0, irq_to_cpu = '0;

    int checks = 0;
    int failures = 0;
    logic seen_clr = 1'b0, seen_set = 1'b0;
    logic [9:0] seen_clr_id = '0, seen_set_id = '0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    ackeoi_tracker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_ackeoi_tracker (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .hp_id(hp_id),
        .prio_tbl(prio_tbl), .irq_enable(irq_enable), .irq_edge(irq_edge),
        .irq_level(irq_level), .irq_to_cpu(irq_to_cpu), .cpu_irq(cpu_irq),
        .pend_clr_vld(pend_clr_vld), .pend_clr_id(pend_clr_id),
        .pend_set_vld(pend_set_vld), .pend_set_id(pend_set_id));

    always @(posedge clk) begin
        if (pend_clr_vld) begin seen_clr <= 1'b1; seen_clr_id <= pend_clr_id; end
        if (pend_set_vld) begin seen_set <= 1'b1; seen_set_id <= pend_set_id; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_seen();
        @(negedge clk);
        seen_clr = 1'b0;
        seen_set = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        while (!bus_ready) @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R12 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(bus_ready), 32'd1);
        chk("R1 cpu_irq", 32'(cpu_irq), 32'd0);
        chk("R1 no pulse", 32'(pend_clr_vld | pend_set_vld), 32'd0);
        bus_read(8'h14, rd); chk("R1 R5 run prio", rd, 32'h100);
        bus_read(8'h00, rd); chk("R1 ctrl", rd, 32'd0);
        bus_read(8'h04, rd); chk("R1 pmask", rd, 32'd0);
    endtask

    task automatic t_disabled();
        bus_write(8'h04, 32'hFF);
        hp_id = 10'd5;
        bus_read(8'h18, rd); chk("R2 disabled hp", rd, 32'd1023);
        clear_seen();
        bus_read(8'h0C, rd); chk("R3 disabled ack", rd, 32'd1023);
        settle(); chk("R3 no clear", 32'(seen_clr), 32'd0);
    endtask

    task automatic t_ack_basic();
        bus_write(8'h00, 32'h1);
        bus_read(8'h18, rd); chk("R2 hp", rd, 32'd5);
        chk("R2 cpu_irq on", 32'(cpu_irq), 32'd1);
        clear_seen();
        bus_read(8'h0C, rd); chk("R4 ack id", rd, 32'd5);
        settle();
        chk("R4 clear pulse", 32'(seen_clr), 32'd1);
        chk("R4 clear id", 32'(seen_clr_id), 32'd5);
        bus_read(8'h14, rd); chk("R4 run prio", rd, 32'h40);
        chk("R2 cpu_irq off", 32'(cpu_irq), 32'd0);
    endtask

    task automatic t_ack_equal();
        hp_id = 10'd6;
        clear_seen();
        bus_read(8'h0C, rd); chk("R3 equal prio ack", rd, 32'd1023);
        settle(); chk("R3 equal no clear", 32'(seen_clr), 32'd0);
        bus_read(8'h14, rd); chk("R3 run prio kept", rd, 32'h40);
        bus_read(8'h18, rd); chk("R2 hp offered", rd, 32'd6);
    endtask

    task automatic t_nest_middle();
        hp_id = 10'd7; bus_read(8'h0C, rd); chk("R4 ack 7", rd, 32'd7);
        hp_id = 10'd9; bus_read(8'h0C, rd); chk("R4 ack 9", rd, 32'd9);
        hp_id = 10'd1023;
        bus_write(8'h10, 32'd7);
        chk("R9 ready low in walk", 32'(bus_ready), 32'd0);
        bus_read(8'h14, rd); chk("R9 running kept", rd, 32'h10);
        bus_write(8'h10, 32'd9);
        bus_read(8'h14, rd); chk("R8 R9 pop skips 7", rd, 32'h40);
        bus_write(8'h10, 32'd5);
        bus_read(8'h14, rd); chk("R5 R8 idle", rd, 32'h100);
    endtask

    task automatic t_idle_eoi();
        irq_enable[5] = 1'b1; irq_level[5] = 1'b1; irq_to_cpu[5] = 1'b1;
        clear_seen();
        bus_write(8'h10, 32'd5);
        settle(); chk("R7 no repend idle", 32'(seen_set), 32'd0);
        bus_read(8'h14, rd); chk("R7 still idle", rd, 32'h100);
    endtask

    task automatic t_bad_eoi();
        irq_enable[12] = 1'b1; irq_level[12] = 1'b1; irq_to_cpu[12] = 1'b1;
        hp_id = 10'd12; bus_read(8'h0C, rd); chk("R4 ack 12", rd, 32'd12);
        hp_id = 10'd1023;
        clear_seen();
        bus_write(8'h10, 32'h3FF);
        bus_read(8'h14, rd); chk("R6 eoi 1023 ignored", rd, 32'h30);
        bus_write(8'h10, 32'd64);
        bus_read(8'h14, rd); chk("R6 eoi 64 ignored", rd, 32'h30);
        settle(); chk("R6 no repend", 32'(seen_set), 32'd0);
    endtask

    task automatic t_repend();
        clear_seen();
        bus_write(8'h10, 32'd12);
        settle();
        chk("R10 repend pulse", 32'(seen_set), 32'd1);
        chk("R10 repend id", 32'(seen_set_id), 32'd12);
        bus_read(8'h14, rd); chk("R10 R8 pop same access", rd, 32'h100);
        irq_edge[13] = 1'b1; irq_enable[13] = 1'b1; irq_level[13] = 1'b1; irq_to_cpu[13] = 1'b1;
        hp_id = 10'd13; bus_read(8'h0C, rd); chk("R4 ack 13", rd, 32'd13);
        hp_id = 10'd1023;
        clear_seen();
        bus_write(8'h10, 32'd13);
        settle(); chk("R10 edge no repend", 32'(seen_set), 32'd0);
    endtask

    task automatic t_mask();
        bus_write(8'h04, 32'h30);
        hp_id = 10'd12;
        bus_read(8'h18, rd); chk("R2 masked hp", rd, 32'd1023);
        bus_read(8'h0C, rd); chk("R3 masked ack", rd, 32'd1023);
        bus_write(8'h04, 32'h31);
        bus_read(8'h18, rd); chk("R2 unmasked hp", rd, 32'd12);
        hp_id = 10'd1023;
        bus_write(8'h04, 32'hFF);
    endtask

    task automatic t_undef();
        bus_write(8'h20, 32'h0);
        bus_write(8'h08, 32'h0);
        bus_read(8'h00, rd); chk("R11 ctrl kept", rd, 32'd1);
        bus_read(8'h04, rd); chk("R11 pmask kept", rd, 32'hFF);
        bus_read(8'h20, rd); chk("R11 undef read", rd, 32'd0);
        bus_read(8'h10, rd); chk("R11 eoi read zero", rd, 32'd0);
    endtask

    task automatic t_deep_walk();
        hp_id = 10'd20; bus_read(8'h0C, rd); chk("R4 ack 20", rd, 32'd20);
        hp_id = 10'd21; bus_read(8'h0C, rd); chk("R4 ack 21", rd, 32'd21);
        hp_id = 10'd22; bus_read(8'h0C, rd); chk("R4 ack 22", rd, 32'd22);
        hp_id = 10'd23; bus_read(8'h0C, rd); chk("R4 ack 23", rd, 32'd23);
        hp_id = 10'd1023;
        bus_write(8'h10, 32'd20);
        chk("R9 deep walk busy", 32'(bus_ready), 32'd0);
        bus_read(8'h14, rd); chk("R9 deep running kept", rd, 32'h30);
        bus_write(8'h10, 32'd23);
        bus_read(8'h14, rd); chk("R8 pop to 22", rd, 32'h40);
        bus_write(8'h10, 32'd22);
        bus_read(8'h14, rd); chk("R8 pop to 21", rd, 32'h50);
        bus_write(8'h10, 32'd21);
        bus_read(8'h14, rd); chk("R9 spliced end idle", rd, 32'h100);
    endtask

    initial begin
        for (int i = 0; i < NUM_IRQ; i++) prio_tbl[i*PRIO_W +: PRIO_W] = 8'h80;
        prio_tbl[5*8 +: 8]  = 8'h40;
        prio_tbl[6*8 +: 8]  = 8'h40;
        prio_tbl[7*8 +: 8]  = 8'h20;
        prio_tbl[9*8 +: 8]  = 8'h10;
        prio_tbl[12*8 +: 8] = 8'h30;
        prio_tbl[13*8 +: 8] = 8'h30;
        prio_tbl[20*8 +: 8] = 8'h60;
        prio_tbl[21*8 +: 8] = 8'h50;
        prio_tbl[22*8 +: 8] = 8'h40;
        prio_tbl[23*8 +: 8] = 8'h30;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ack_basic();
        t_ack_equal();
        t_nest_middle();
        t_idle_eoi();
        t_bad_eoi();
        t_repend();
        t_mask();
        t_undef();
        t_deep_walk();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule